// File: doc/BRIEF.md
# Six-Source Interrupt Enable and Priority Controller

This block collects interrupt requests from six sources (two external inputs, three timers and a serial port) and holds each one in a pending flag. Each request passes only if its own enable bit and a global enable bit are both set. The highest-ranked request that passes is offered to the processor side as a 3-bit vector index with a valid strobe. The timer-2 request is the OR of two flags, an overflow flag and an external-event flag.

Software reaches three byte registers over a small write/read bus: the enable register, the priority register, and the flag register. Flags are cleared by writing ones to the flag register. Each source belongs to one of two levels, set by its priority bit. A high-level request can preempt a low-level handler that is running, but nothing preempts a high-level handler.

The processor accepts the offered vector with an acknowledge pulse and ends a handler with a return pulse. On acknowledge, the flags of the two external sources and of timers 0 and 1 clear automatically. The serial flag and both timer-2 flags stay set until software clears them.

Top module: `irq6_ctrl`

## Requirements
- R1: Synchronous reset clears all pending flags, the enable register, the priority register and both in-service levels. After reset, `irq_valid` is 0 and every register reads 0.
- R2: A 1 on `src_pulse[i]` sets flag i. Flag i is cleared by a write to address 2 with bit i set. Flag layout at address 2: bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial, bit5 timer-2 overflow, bit6 timer-2 event, bit7 reads 0. If a pulse and a clear hit the same flag in the same cycle, the flag is set.
- R3: The enable register is at address 0. Bits 0..5 enable vectors 0..5 and bit 7 is the global enable. Bit 6 is reserved: a 1 written to it has no effect and it reads 0.
- R4: While enable bit 7 is 0, no request is offered, whatever the other enable bits are.
- R5: The priority register is at address 1. Bit i set puts vector i in the high level. Bits 7 and 6 are reserved, ignore writes and read 0.
- R6: Vector indices and the fixed order within one level, first to last, are: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2. Among competing requests of the same level, the lowest index is offered.
- R7: With no handler in service, a pending enabled high-level request is offered ahead of any low-level one.
- R8: While a low-level handler is in service, only high-level requests are offered. While a high-level handler is in service, no request is offered.
- R9: A pulse on `irq_ret` ends the high-level handler if one is in service. Otherwise it ends the low-level handler.
- R10: Acknowledging vector 0, 1, 2 or 3 clears that source's flag. Acknowledging vector 4 leaves the serial flag set.
- R11: Vector 5 is requested while either timer-2 flag is set. Neither timer-2 flag is cleared by acknowledge; only a software write clears them.
- R12: `irq_valid` and `irq_vec` are registered from the state of the previous cycle, and `irq_valid` is 0 in the cycle after an accepted acknowledge. `reg_rdata` shows the register selected by `reg_addr` one cycle later, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 7 | One-cycle flag-set pulses, in the bit order of the flag register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address: 0 enable, 1 priority, 2 flags |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for `reg_addr` |
| irq_ack | input | 1 | Processor accepts the offered vector (used only while `irq_valid` is 1) |
| irq_ret | input | 1 | Processor leaves the current handler |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | 3 | Index of the offered vector |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 2-bit address. Because the address is 2 bits wide, the one unmapped address can be reached, and every bit of each byte register, including the reserved bits, can be written and read back. Within this space, random pulses, register writes, acknowledges and returns move the controller through the no-handler, low-in-service and high-in-service states under changing enable and priority masks. Directed steps add the global-off case, timer 2 raised by its event flag alone, and a flag pulse that meets a clear in the same cycle.

// File: rtl/irq6_pkg.sv
package irq6_pkg;
  localparam int NSRC  = 6;
  localparam int NFLAG = 7;
  localparam int GBIT  = 7;

  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_PRI = 2'd1;
  localparam logic [1:0] ADDR_FLG = 2'd2;

  localparam logic [7:0] EN_WMASK  = 8'hBF;
  localparam logic [7:0] PRI_WMASK = 8'h3F;

  // Vectors whose flag is cleared when the vector is acknowledged
  localparam logic [NSRC-1:0] HW_CLR_MASK = 6'b001111;
endpackage

// File: rtl/irq6_regs.sv
module irq6_regs
  import irq6_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] pri_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (wr) begin
      if (addr == AW'(ADDR_EN))  en_q  <= wdata & DW'(EN_WMASK);
      if (addr == AW'(ADDR_PRI)) pri_q <= wdata & DW'(PRI_WMASK);
    end
  end
endmodule

// File: rtl/irq6_flags.sv
module irq6_flags
  import irq6_pkg::*;
#(
  parameter int NF = 7,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_pulse,
  input  logic [NF-1:0] hw_clr,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flg_q
);
  logic [NF-1:0] sw_clr;
  assign sw_clr = (wr && addr == AW'(ADDR_FLG)) ? wdata : '0;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                       flg_q[i] <= 1'b0;
      else if (set_pulse[i])         flg_q[i] <= 1'b1;
      else if (sw_clr[i] || hw_clr[i]) flg_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq6_arb.sv
module irq6_arb
  import irq6_pkg::*;
#(
  parameter int NS = 6,
  parameter int NF = 7,
  localparam int VW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          glob_en,
  input  logic [NS-1:0] src_en,
  input  logic [NS-1:0] src_pri,
  input  logic [NF-1:0] flg,
  input  logic          ack,
  input  logic          ret,
  output logic          valid_q,
  output logic [VW-1:0] vec_q,
  output logic [NF-1:0] hw_clr,
  output logic          insvc_lo,
  output logic          insvc_hi
);
  logic [NS-1:0] pend, req, hi_req, lo_req, cand;
  logic          pick_vld, lvl_q, take, lo_n, hi_n;
  logic [VW-1:0] pick_idx;

  // Last vector requests on either of the two remaining flags
  assign pend   = {|flg[NF-1:NS-1], flg[NS-2:0]};
  assign req    = pend & src_en & {NS{glob_en}};
  assign hi_req = req & src_pri;
  assign lo_req = req & ~src_pri;
  assign take   = ack && valid_q;

  always_comb begin
    if (insvc_hi)      cand = '0;
    else if (insvc_lo) cand = hi_req;
    else               cand = (|hi_req) ? hi_req : lo_req;
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_vld = 1'b1;
        pick_idx = VW'(i);
      end
    end
  end

  always_comb begin
    hw_clr = '0;
    if (take && HW_CLR_MASK[vec_q]) hw_clr[vec_q] = 1'b1;
  end

  always_comb begin
    lo_n = insvc_lo;
    hi_n = insvc_hi;
    if (ret) begin
      if (insvc_hi) hi_n = 1'b0;
      else          lo_n = 1'b0;
    end
    if (take) begin
      if (lvl_q) hi_n = 1'b1;
      else       lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      vec_q    <= '0;
      lvl_q    <= 1'b0;
      insvc_lo <= 1'b0;
      insvc_hi <= 1'b0;
    end else begin
      valid_q  <= pick_vld && !take;
      vec_q    <= pick_idx;
      lvl_q    <= src_pri[pick_idx];
      insvc_lo <= lo_n;
      insvc_hi <= hi_n;
    end
  end
endmodule

// File: rtl/irq6_ctrl.sv
module irq6_ctrl
  import irq6_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] src_pulse,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_valid,
  output logic [2:0]       irq_vec
);
  localparam int VW = $clog2(NSRC);

  logic [DW-1:0]    en_q, pri_q;
  logic [NFLAG-1:0] flg_q, hw_clr;
  logic             insvc_lo, insvc_hi;
  logic [VW-1:0]    vec_w;

  irq6_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .pri_q(pri_q)
  );

  irq6_flags #(.NF(NFLAG), .AW(AW)) u_flags (
    .clk(clk), .rst(rst), .set_pulse(src_pulse), .hw_clr(hw_clr),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata[NFLAG-1:0]), .flg_q(flg_q)
  );

  irq6_arb #(.NS(NSRC), .NF(NFLAG)) u_arb (
    .clk(clk), .rst(rst), .glob_en(en_q[GBIT]),
    .src_en(en_q[NSRC-1:0]), .src_pri(pri_q[NSRC-1:0]), .flg(flg_q),
    .ack(irq_ack), .ret(irq_ret), .valid_q(irq_valid), .vec_q(vec_w),
    .hw_clr(hw_clr), .insvc_lo(insvc_lo), .insvc_hi(insvc_hi)
  );

  assign irq_vec = 3'(vec_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        AW'(ADDR_EN):  reg_rdata <= en_q;
        AW'(ADDR_PRI): reg_rdata <= pri_q;
        AW'(ADDR_FLG): reg_rdata <= DW'(flg_q);
        default:       reg_rdata <= '0;
      endcase
    end
  end
endmodule

module irq6_ctrl_chk
  import irq6_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             irq_ack,
  input logic             irq_valid,
  input logic [2:0]       irq_vec,
  input logic [DW-1:0]    en_q,
  input logic [NFLAG-1:0] flg_q,
  input logic [NFLAG-1:0] hw_clr,
  input logic             insvc_hi
);
  a_r3_en_write_mask: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(ADDR_EN) && !rst) |=> (en_q == ($past(reg_wdata) & DW'(EN_WMASK))));

  a_r4_global_blocks: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q[GBIT]) |-> !irq_valid);

  a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vec < 3'(NSRC)));

  a_r8_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    insvc_hi |=> !irq_valid);

  a_r10_one_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hw_clr));

  a_r11_t2_sw_only: assert property (@(posedge clk) disable iff (rst)
    ((flg_q[6:5] != 2'b00) && !rst && !(reg_wr && reg_addr == AW'(ADDR_FLG)))
    |=> ((flg_q[6:5] & $past(flg_q[6:5])) == $past(flg_q[6:5])));

  a_r12_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> !irq_valid);
endmodule

bind irq6_ctrl irq6_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_ack(irq_ack), .irq_valid(irq_valid),
  .irq_vec(irq_vec), .en_q(en_q), .flg_q(flg_q), .hw_clr(hw_clr),
  .insvc_hi(insvc_hi)
);

// File: tb/irq6_ctrl_tb.sv
module irq6_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] src_pulse = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_en, m_pri;
  logic [6:0] m_flg;
  bit         m_lo, m_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq6_ctrl u_dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  function automatic int exp_vec();
    logic [5:0] pend, req, hi, lo, c;
    pend = {m_flg[6] | m_flg[5], m_flg[4:0]};
    req  = pend & m_en[5:0] & {6{m_en[7]}};
    hi   = req & m_pri[5:0];
    lo   = req & ~m_pri[5:0];
    if (m_hi)      c = '0;
    else if (m_lo) c = hi;
    else           c = (hi != 0) ? hi : lo;
    for (int i = 0; i < 6; i++) if (c[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_pri = '0; m_flg = '0; m_lo = 0; m_hi = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    case (a)
      2'd0: m_en  = d & 8'hBF;
      2'd1: m_pri = d & 8'h3F;
      2'd2: m_flg = m_flg & ~d[6:0];
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] b);
    @(negedge clk); src_pulse = b;
    @(negedge clk); src_pulse = '0;
    m_flg = m_flg | b;
  endtask

  task automatic do_ack();
    int v;
    v = exp_vec();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R12 valid low after ack", {31'd0, irq_valid}, 32'd0);
    if (v >= 0) begin
      if (m_pri[v]) m_hi = 1; else m_lo = 1;
      if (v < 4) m_flg[v] = 1'b0;
    end
  endtask

  task automatic do_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    if (m_hi) m_hi = 0; else m_lo = 0;
  endtask

  task automatic check_out(input string tag);
    int v;
    @(negedge clk);
    v = exp_vec();
    check({tag, " valid"}, {31'd0, irq_valid}, (v >= 0) ? 32'd1 : 32'd0);
    if (v >= 0) check({tag, " vec"}, {29'd0, irq_vec}, 32'(v));
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] d;
    bus_rd(2'd0, d); check({tag, " en"},    {24'd0, d}, {24'd0, m_en});
    bus_rd(2'd1, d); check({tag, " pri"},   {24'd0, d}, {24'd0, m_pri});
    bus_rd(2'd2, d); check({tag, " flags"}, {24'd0, d}, {25'd0, m_flg});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    model_reset();
    do_reset();

    // R1: reset state
    check_out("R1 reset");
    check_regs("R1 reset");

    // R3 / R5: reserved bits
    bus_wr(2'd0, 8'hFF); bus_rd(2'd0, d); check("R3 en reserved", {24'd0, d}, 32'hBF);
    bus_wr(2'd1, 8'hFF); bus_rd(2'd1, d); check("R5 pri reserved", {24'd0, d}, 32'h3F);
    bus_rd(2'd3, d); check("R12 unmapped read", {24'd0, d}, 32'h0);
    bus_wr(2'd1, 8'h00);

    // R4: global off blocks all
    bus_wr(2'd0, 8'h3F);
    pulse(7'h7F);
    check_out("R4 global off");
    bus_rd(2'd2, d); check("R2 flags set", {24'd0, d}, 32'h7F);

    // R6, R8, R9, R10: order, low in service, return
    bus_wr(2'd0, 8'hBF); check_out("R6 order ext0 first");
    do_ack();            check_out("R8 low in service");
    bus_rd(2'd2, d); check("R10 ext0 cleared", {24'd0, d}, 32'h7E);
    do_ret();            check_out("R9 return then timer0");

    // R7, R8, R11: timer2 high level preempts
    bus_wr(2'd1, 8'h20); check_out("R7 high first");
    do_ack();            check_out("R8 high blocks");
    bus_rd(2'd2, d); check("R11 t2 flags kept", {24'd0, d}, 32'h7E);
    do_ret();            check_out("R9 pop high");
    bus_wr(2'd1, 8'h00); check_out("R6 timer0 next");
    do_ack();            check_out("R8 low only");
    bus_wr(2'd1, 8'h20); check_out("R8 high preempts low");
    do_ack();            check_out("R8 nested high");
    do_ret();            check_out("R9 pop high first");
    do_ret();            check_out("R9 pop low");

    // R10: serial flag survives ack
    bus_wr(2'd2, 8'h6F); bus_wr(2'd1, 8'h00); check_out("R6 serial only");
    do_ack(); do_ret();
    bus_rd(2'd2, d); check("R10 serial kept", {24'd0, d}, 32'h10);

    // R11: timer2 via event flag only
    bus_wr(2'd2, 8'h7F); pulse(7'h40); check_out("R11 event flag");
    bus_wr(2'd2, 8'h20); check_out("R11 overflow clear no effect");
    bus_wr(2'd2, 8'h40); check_out("R11 event cleared");

    // R2: pulse and clear same cycle, set wins
    @(negedge clk); src_pulse = 7'h10; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h10;
    @(negedge clk); src_pulse = '0; reg_wr = 1'b0;
    m_flg[4] = 1'b1;
    bus_rd(2'd2, d); check("R2 set wins", {24'd0, d}, 32'h10);

    // Random phase: R2..R11
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: pulse(7'($urandom));
        2:    bus_wr(2'd0, ($urandom_range(0, 3) != 0) ? (8'($urandom) | 8'h80) : 8'($urandom));
        3:    bus_wr(2'd1, 8'($urandom));
        4:    bus_wr(2'd2, 8'($urandom) & 8'($urandom));
        5, 6, 7: if (exp_vec() >= 0) do_ack();
        default: do_ret();
      endcase
      check_out("R6 R7 R8 R9 R11 random");
      if (it % 8 == 0) check_regs("R2 R3 R5 R10 random");
    end

    // R1: reset after activity
    bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'h3F); pulse(7'h7F);
    do_reset();
    check_out("R1 second reset");
    check_regs("R1 second reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule